// File: doc/BRIEF.md
# Communication bit manipulation unit

This unit handles the bit-level steps of a baseband transmit chain in a single cycle per word. It can scramble a word with a self-synchronising x^7 + x^4 + 1 scrambler. It can encode a word with a rate-1/2 convolutional encoder whose two tap masks are programmable. It can interleave two words bit by bit. It can puncture a word under a keep mask and pack the surviving bits at the bottom of the result. The scrambler state and the encoder history live in the unit and carry over from one operation to the next. A software-visible stream can therefore be split across many words and still produce the same bit sequence as one long serial pass.

Operations arrive on a valid/ready port. Each carries a 3-bit opcode and two operand words. Every accepted operation produces exactly one result on a valid/ready output: a data word twice the operand width, plus a count of meaningful bits. Within a word, bits are consumed and produced least significant first.

Top module: `bitop_unit`

## Requirements
- R1: A synchronous active-high reset clears out_valid. It zeroes the 7-bit scrambler state, the encoder history and both encoder tap masks.
- R2: in_ready is high whenever out_valid is low or out_ready is high. An accepted operation shows its result on the next cycle with out_valid high. While out_valid is high and out_ready is low, out_data and out_count hold.
- R3: Opcode 2 scrambles in_a. For bit i, taken in ascending order, the output is in_a[i] XOR s[3] XOR s[6], and the state then becomes {s[5:0], output}. The result sits in out_data[W-1:0], the upper half is zero, and the count is W.
- R4: The scrambler state persists between operations. Opcode 0 loads it from in_a[6:0].
- R5: Opcode 3 encodes in_a. For bit i the window is {h, in_a[i]}, with the current bit at position 0. Output A is the XOR of the window bits selected by mask A, and output B likewise with mask B. A is written to out_data[2i] and B to out_data[2i+1]. The history then becomes {h[K-3:0], in_a[i]}. The count is 2W.
- R6: The encoder history persists between operations, and opcode 0 loads it from in_b[K-2:0]. Opcode 1 loads mask A from in_a[K-1:0] and mask B from in_b[K-1:0].
- R7: Opcode 4 interleaves the operands: out_data[2i] = in_a[i] and out_data[2i+1] = in_b[i]. The count is 2W.
- R8: Opcode 5 keeps in_a[i] wherever in_b[i] is 1 and packs the kept bits from out_data[0] upward in ascending i. The count is the number of ones in in_b, and all bits at or above the count are zero.
- R9: Opcodes 0 and 1 return data 0 with count 0. Opcodes 4 and 5 leave the scrambler and encoder state untouched.
- R10: Opcodes 6 and 7 return data 0 with count 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 3 | Opcode |
| in_a | input | W | First operand (data) |
| in_b | input | W | Second operand (second stream, mask or seed) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer ready |
| out_data | output | 2W | Result bits |
| out_count | output | clog2(2W+1) | Number of meaningful result bits |

## Verification
The bench builds the unit with its defaults: 16-bit operand words and a constraint length of 9. With these values, one scramble word runs the 7-bit state through more than two full turns. An encoder mask can reach all nine window taps, including history bits that were loaded by a seed or carried over from an earlier word. A puncture mask can keep anywhere from none to all sixteen bits. A bit-serial model in the bench follows the state across a directed table, a long random run, a stalled output and a mid-stream reset.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int OP_W        = 3;
    localparam int SCR_LEN     = 7;
    localparam int SCR_TAP_NEAR = 3;  // delay-4 tap of x^4
    localparam int SCR_TAP_FAR  = 6;  // delay-7 tap of x^7

    typedef enum logic [OP_W-1:0] {
        OP_SEED   = 3'd0,
        OP_TAPS   = 3'd1,
        OP_SCRAM  = 3'd2,
        OP_CONV   = 3'd3,
        OP_MUX    = 3'd4,
        OP_PUNCT  = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } bop_e;

    typedef struct packed {
        logic ld_seed;
        logic ld_taps;
        logic scr_step;
        logic enc_step;
    } bop_ctl_t;

    function automatic bop_ctl_t decode_op(input logic fire, input logic [OP_W-1:0] op);
        bop_ctl_t c;
        c = '0;
        if (fire) begin
            case (bop_e'(op))
                OP_SEED:  c.ld_seed  = 1'b1;
                OP_TAPS:  c.ld_taps  = 1'b1;
                OP_SCRAM: c.scr_step = 1'b1;
                OP_CONV:  c.enc_step = 1'b1;
                default:  c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/bmu_scrambler.sv
module bmu_scrambler
    import bitop_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SCR_LEN-1:0] seed,
    input  logic               step,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       dout
);

    logic [SCR_LEN-1:0] state_q;
    logic [SCR_LEN-1:0] state_n;

    always_comb begin
        logic [SCR_LEN-1:0] s;
        logic y;
        s    = state_q;
        dout = '0;
        for (int i = 0; i < W; i++) begin
            y       = din[i] ^ s[SCR_TAP_NEAR] ^ s[SCR_TAP_FAR];
            dout[i] = y;
            s       = {s[SCR_LEN-2:0], y};
        end
        state_n = s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= seed;
        end else if (step) begin
            state_q <= state_n;
        end
    end

endmodule

// File: rtl/bmu_convenc.sv
module bmu_convenc #(
    parameter int W = 16,
    parameter int K = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_hist,
    input  logic [K-2:0] hist_seed,
    input  logic         load_taps,
    input  logic [K-1:0] taps_a,
    input  logic [K-1:0] taps_b,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] code_a,
    output logic [W-1:0] code_b
);

    localparam int HL = K - 1;

    logic [HL-1:0] hist_q;
    logic [HL-1:0] hist_n;
    logic [K-1:0]  mask_a_q;
    logic [K-1:0]  mask_b_q;

    always_comb begin
        logic [HL-1:0] h;
        logic [K-1:0]  win;
        h      = hist_q;
        code_a = '0;
        code_b = '0;
        for (int i = 0; i < W; i++) begin
            win       = {h, din[i]};
            code_a[i] = ^(win & mask_a_q);
            code_b[i] = ^(win & mask_b_q);
            h         = win[HL-1:0];
        end
        hist_n = h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q   <= '0;
            mask_a_q <= '0;
            mask_b_q <= '0;
        end else begin
            if (load_hist) begin
                hist_q <= hist_seed;
            end else if (step) begin
                hist_q <= hist_n;
            end
            if (load_taps) begin
                mask_a_q <= taps_a;
                mask_b_q <= taps_b;
            end
        end
    end

endmodule

// File: rtl/bmu_puncture.sv
module bmu_puncture #(
    parameter int W  = 16,
    localparam int KW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  keep,
    output logic [W-1:0]  packed_bits,
    output logic [KW-1:0] kept
);

    always_comb begin
        int slot;
        slot        = 0;
        packed_bits = '0;
        for (int i = 0; i < W; i++) begin
            if (keep[i]) begin
                packed_bits[slot] = din[i];
                slot = slot + 1;
            end
        end
        kept = KW'(slot);
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int W  = 16,
    parameter int K  = 9,
    localparam int OW = 2 * W,
    localparam int CW = $clog2(OW + 1),
    localparam int KW = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    in_a,
    input  logic [W-1:0]    in_b,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [OW-1:0]   out_data,
    output logic [CW-1:0]   out_count
);

    logic     fire;
    bop_ctl_t ctl;

    logic [W-1:0]  scr_word;
    logic [W-1:0]  enc_a;
    logic [W-1:0]  enc_b;
    logic [W-1:0]  pun_word;
    logic [KW-1:0] pun_cnt;
    logic [W-1:0]  lane_even;
    logic [W-1:0]  lane_odd;
    logic [OW-1:0] woven;
    logic [OW-1:0] res_data;
    logic [CW-1:0] res_count;

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign ctl      = decode_op(fire, in_op);

    bmu_scrambler #(.W(W)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.ld_seed),
        .seed (in_a[SCR_LEN-1:0]),
        .step (ctl.scr_step),
        .din  (in_a),
        .dout (scr_word)
    );

    bmu_convenc #(.W(W), .K(K)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .load_hist (ctl.ld_seed),
        .hist_seed (in_b[K-2:0]),
        .load_taps (ctl.ld_taps),
        .taps_a    (in_a[K-1:0]),
        .taps_b    (in_b[K-1:0]),
        .step      (ctl.enc_step),
        .din       (in_a),
        .code_a    (enc_a),
        .code_b    (enc_b)
    );

    bmu_puncture #(.W(W)) u_pun (
        .din         (in_a),
        .keep        (in_b),
        .packed_bits (pun_word),
        .kept        (pun_cnt)
    );

    // The encoder reuses the bit-weaving network of the multiplex operation.
    assign lane_even = (bop_e'(in_op) == OP_CONV) ? enc_a : in_a;
    assign lane_odd  = (bop_e'(in_op) == OP_CONV) ? enc_b : in_b;

    for (genvar g = 0; g < W; g++) begin : g_weave
        assign woven[2*g]   = lane_even[g];
        assign woven[2*g+1] = lane_odd[g];
    end

    always_comb begin
        res_data  = '0;
        res_count = '0;
        case (bop_e'(in_op))
            OP_SCRAM: begin
                res_data  = {{W{1'b0}}, scr_word};
                res_count = CW'(W);
            end
            OP_CONV, OP_MUX: begin
                res_data  = woven;
                res_count = CW'(OW);
            end
            OP_PUNCT: begin
                res_data  = {{W{1'b0}}, pun_word};
                res_count = CW'(pun_cnt);
            end
            default: begin
                res_data  = '0;
                res_count = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_count <= '0;
        end else if (fire) begin
            out_valid <= 1'b1;
            out_data  <= res_data;
            out_count <= res_count;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/bitop_unit_checker.sv
module bitop_unit_checker
    import bitop_pkg::*;
#(
    parameter int W  = 16,
    parameter int K  = 9,
    localparam int OW = 2 * W,
    localparam int CW = $clog2(OW + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic [OP_W-1:0] in_op,
    input logic [W-1:0]    in_a,
    input logic [W-1:0]    in_b,
    input logic            out_valid,
    input logic            out_ready,
    input logic [OW-1:0]   out_data,
    input logic [CW-1:0]   out_count
);

    logic acc;
    assign acc = in_valid && in_ready;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_count));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    assert_scram_count_R3: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_SCRAM |=> out_count == CW'(W) && out_data[OW-1:W] == '0);

    assert_conv_count_R5: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_CONV |=> out_count == CW'(OW));

    assert_mux_bits_R7: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_MUX |=> out_count == CW'(OW)
            && out_data[0] == $past(in_a[0]) && out_data[1] == $past(in_b[0])
            && out_data[OW-1] == $past(in_b[W-1]));

    assert_punct_count_R8: assert property (@(posedge clk) disable iff (rst)
        acc && in_op == OP_PUNCT |=> out_count == CW'($countones($past(in_b))));

    assert_clean_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data >> out_count) == '0);

    assert_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
        acc && (in_op == OP_SEED || in_op == OP_TAPS) |=> out_count == '0 && out_data == '0);

    assert_rsv_R10: assert property (@(posedge clk) disable iff (rst)
        acc && (in_op == OP_RSV6 || in_op == OP_RSV7) |=> out_count == '0 && out_data == '0);

endmodule

bind bitop_unit bitop_unit_checker #(.W(W), .K(K)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_count (out_count)
);

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;

    localparam int W  = 16;
    localparam int K  = 9;
    localparam int OW = 2 * W;
    localparam int CW = $clog2(OW + 1);
    localparam int NV = 17;

    // {op, a, b}
    localparam logic [34:0] VEC [NV] = '{
        {3'd0, 16'h0055, 16'h00A3},
        {3'd1, 16'h0191, 16'h01B7},
        {3'd2, 16'hBEEF, 16'h0000},
        {3'd2, 16'h0000, 16'h0000},
        {3'd2, 16'hFFFF, 16'h0000},
        {3'd3, 16'h1234, 16'h0000},
        {3'd3, 16'hFFFF, 16'h0000},
        {3'd3, 16'h0001, 16'h0000},
        {3'd4, 16'hFF00, 16'h0F0F},
        {3'd4, 16'hA5A5, 16'h5A5A},
        {3'd5, 16'hDEAD, 16'hFFFF},
        {3'd5, 16'hDEAD, 16'h0000},
        {3'd5, 16'hCAFE, 16'h8001},
        {3'd5, 16'h1357, 16'hAAAA},
        {3'd6, 16'h1111, 16'h2222},
        {3'd7, 16'h3333, 16'h4444},
        {3'd2, 16'h0F0F, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_op = '0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [OW-1:0] out_data;
    logic [CW-1:0] out_count;

    int n_tests = 0;
    int n_fail  = 0;

    // bench-side bit-serial model state
    logic [6:0]   m_scr;
    logic [K-2:0] m_hist;
    logic [K-1:0] m_ma;
    logic [K-1:0] m_mb;

    always #2.5 clk = ~clk;

    bitop_unit #(.W(W), .K(K)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_count (out_count)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R9";
            3'd2:       return "R3/R4";
            3'd3:       return "R5/R6";
            3'd4:       return "R7";
            3'd5:       return "R8";
            default:    return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_scr = '0; m_hist = '0; m_ma = '0; m_mb = '0;
    endtask

    task automatic model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [OW-1:0] ed, output logic [CW-1:0] ec);
        logic y;
        logic [K-1:0] win;
        int n;
        ed = '0; ec = '0;
        case (op)
            3'd0: begin m_scr = a[6:0]; m_hist = b[K-2:0]; end
            3'd1: begin m_ma = a[K-1:0]; m_mb = b[K-1:0]; end
            3'd2: begin
                for (int i = 0; i < W; i++) begin
                    y = a[i] ^ m_scr[3] ^ m_scr[6];
                    ed[i] = y;
                    m_scr = {m_scr[5:0], y};
                end
                ec = CW'(W);
            end
            3'd3: begin
                for (int i = 0; i < W; i++) begin
                    win = {m_hist, a[i]};
                    ed[2*i]   = ^(win & m_ma);
                    ed[2*i+1] = ^(win & m_mb);
                    m_hist = {m_hist[K-3:0], a[i]};
                end
                ec = CW'(OW);
            end
            3'd4: begin
                for (int i = 0; i < W; i++) begin
                    ed[2*i] = a[i]; ed[2*i+1] = b[i];
                end
                ec = CW'(OW);
            end
            3'd5: begin
                n = 0;
                for (int i = 0; i < W; i++) begin
                    if (b[i]) begin ed[n] = a[i]; n++; end
                end
                ec = CW'(n);
            end
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [OW-1:0] ed;
        logic [CW-1:0] ec;
        model(op, a, b, ed, ec);
        @(negedge clk);
        out_ready = 1'b1;
        in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
        chk(in_ready == 1'b1, "R2 ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R2 valid", 64'(out_valid), 64'd1);
        chk(out_data == ed, tag_of(op), 64'(out_data), 64'(ed));
        chk(out_count == ec, tag_of(op), 64'(out_count), 64'(ec));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [OW-1:0] ed1, ed2, held;
        logic [CW-1:0] ec1, ec2;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        // R1: zero scrambler state and zero masks right after reset
        run_op(3'd2, 16'h8001, 16'h0);
        run_op(3'd3, 16'hFFFF, 16'h0);

        // directed table; repeated scramble/conv entries check R4 and R6 persistence
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][34:32], VEC[i][31:16], VEC[i][15:0]);
        end

        // random run over all opcodes
        for (int i = 0; i < 400; i++) begin
            run_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom));
        end

        // R2: backpressure holds the result and blocks the next operation
        model(3'd4, 16'h1C3A, 16'h9E71, ed1, ec1);
        model(3'd5, 16'hF0F0, 16'h3CC3, ed2, ec2);
        @(negedge clk);
        out_ready = 1'b0;
        in_op = 3'd4; in_a = 16'h1C3A; in_b = 16'h9E71; in_valid = 1'b1;
        @(negedge clk);
        in_op = 3'd5; in_a = 16'hF0F0; in_b = 16'h3CC3;
        chk(in_ready == 1'b0, "R2 stall", 64'(in_ready), 64'd0);
        chk(out_data == ed1, "R2 first", 64'(out_data), 64'(ed1));
        held = out_data;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b1 && out_data == held && out_count == ec1,
                "R2 hold", 64'(out_data), 64'(held));
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data == ed2 && out_count == ec2, "R2 second", 64'(out_data), 64'(ed2));

        // R9: mux and puncture leave the state alone; a scramble afterwards proves it
        run_op(3'd4, 16'hFFFF, 16'hFFFF);
        run_op(3'd5, 16'hFFFF, 16'hFFFF);
        run_op(3'd2, 16'h5555, 16'h0);
        run_op(3'd3, 16'h00FF, 16'h0);

        // R1: reset in mid-stream clears a pending result and all state
        @(negedge clk);
        out_ready = 1'b0;
        in_op = 3'd4; in_a = 16'h1234; in_b = 16'h5678; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        out_ready = 1'b1;
        model_reset();
        run_op(3'd2, 16'hACE1, 16'h0);
        run_op(3'd3, 16'hACE1, 16'h0);

        finish_run();
    end

endmodule